// File: doc/BRIEF.md
# Byte-Stream Hamming Code Generator

This block watches a stream of bytes and builds 24-bit Hamming-style parity codes over fixed-size pages. With these codes a later reader can correct any single flipped bit in a page and detect any two flipped bits. Each accepted byte updates two kinds of parity. Column parity is taken across bit positions of the bytes. Line parity is taken across byte positions, using the parity of each byte and the bits of its index.

A synchronous restart command (`clr`) clears the accumulators, sets the byte count back to zero and captures the page mode from `wide_mode`. In narrow mode the block makes two codes: `code_a` covers the first 256 bytes after the restart and `code_b` covers the next 256. In wide mode a single code covering 512 bytes goes to `code_a`. When the last code of the selected mode is latched, `done` rises. Both code registers then stay frozen until the next restart, even if more bytes arrive.

A three-state sequencer controls the block. Its states are ST_FIRST (collecting the first page), ST_SECOND (collecting the second narrow page) and ST_DONE (frozen). The transitions are:
- ST_FIRST to ST_SECOND on the last byte of the first page in narrow mode.
- ST_FIRST to ST_DONE on byte 511 in wide mode.
- ST_SECOND to ST_DONE on byte 511.
- Any state to ST_FIRST on `clr`.

Top module: `ecc_page_gen`

## Requirements
- R1: After reset, `code_a` and `code_b` read 24'hFFFFFF, `done` is 0 and the block is in narrow mode.
- R2: In narrow mode, `code_a` takes the code of bytes 0–255 after the edge that accepts byte 255, and `code_b` takes the code of bytes 256–511 after the edge that accepts byte 511. Each code uses the index of the byte within its own 256-byte page.
- R3: In wide mode, `code_a` takes the code of all 512 bytes after the edge that accepts byte 511, using a 9-bit byte index. `code_b` stays 24'hFFFFFF, and `code_a` is unchanged before that edge.
- R4: Layout before inversion: for index bit k in 0..7, bit 2k is the even-line parity and bit 2k+1 is the odd-line parity. Bits 17:16 hold the odd/even pair for index bit 8 (wide mode only). Bits 23:18 hold column parity bits 5..0.
- R5: Column parity uses the XOR of all page bytes, c. Bit 2L is the XOR of the bits of c whose position has bit L clear, and bit 2L+1 is the XOR of the bits whose position has bit L set, for L = 0,1,2.
- R6: The even (odd) line parity for index bit k is the XOR of the parities of all bytes whose index has bit k clear (set).
- R7: Every code bit is stored inverted. A page of all 0xFF gives 24'hFFFFFF, and bits 17:16 read 1 in narrow mode.
- R8: `done` rises on the same edge that latches the last code of the selected mode, and not before.
- R9: Once `done` is 1, further bytes change neither code nor `done` until `clr`.
- R10: `clr` wins over a byte presented in the same cycle. After its edge, both codes read 24'hFFFFFF, `done` is 0 and byte counting restarts at 0.
- R11: `wide_mode` is sampled only on a `clr` cycle. Changing it later has no effect on the page size.
- R12: Cycles with `byte_vld` low leave codes, `done` and the byte count unchanged, whatever `byte_in` holds.
- R13: Two pages that differ in exactly one bit give codes that differ in 11 bits in narrow mode and 12 bits in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous restart command; captures `wide_mode` |
| wide_mode | input | 1 | 1 = one 512-byte code, 0 = two 256-byte codes |
| byte_vld | input | 1 | Byte strobe; `byte_in` is taken when high |
| byte_in | input | 8 | Data byte |
| code_a | output | 24 | First code (or the only code in wide mode) |
| code_b | output | 24 | Second code in narrow mode |
| done | output | 1 | Last code of the selected mode is latched |

## Verification
A byte is taken on the rising edge where `byte_vld` is high. A code is due right after the edge that takes the last byte of its page, because the code register loads from the next-value accumulators with no extra pipeline stage. `done` is due on that same edge, and a `clr` takes effect on the edge that samples it. The bench drives inputs on falling edges and leaves `byte_vld` low for one more falling edge after the last byte. It then compares codes and `done` at that falling edge, so each result is sampled half a cycle after its edge. Each page boundary is also checked one byte early, and the frozen state is checked after extra traffic.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int BYTE_W    = 8;
    localparam int COL_BITS  = 6;
    localparam int LINE_MAX  = 9;
    localparam int CODE_W    = 24;

    typedef enum logic [1:0] {
        ST_FIRST,
        ST_SECOND,
        ST_DONE
    } seq_state_t;

    // Build the stored code: pairs of line parity in the low 16 bits, the
    // ninth pair in 17:16 for wide pages, column parity on top, all inverted.
    function automatic logic [CODE_W-1:0] pack_code(
        input logic [LINE_MAX-1:0] ev,
        input logic [LINE_MAX-1:0] od,
        input logic [COL_BITS-1:0] cp,
        input logic                wide
    );
        logic [CODE_W-1:0] raw;
        raw = '0;
        for (int k = 0; k < LINE_MAX - 1; k++) begin
            raw[2*k]   = ev[k];
            raw[2*k+1] = od[k];
        end
        if (wide) begin
            raw[16] = ev[LINE_MAX-1];
            raw[17] = od[LINE_MAX-1];
        end
        raw[CODE_W-1 -: COL_BITS] = cp;
        return ~raw;
    endfunction

endpackage

// File: rtl/ecc_col_par.sv
module ecc_col_par #(
    parameter int BYTE_W = 8,
    localparam int LVLS  = $clog2(BYTE_W),
    localparam int COL_W = 2 * LVLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_acc,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [COL_W-1:0]  col_nxt
);

    logic [BYTE_W-1:0] col_q;
    logic [BYTE_W-1:0] col_sum;

    assign col_sum = take ? (col_q ^ byte_in) : col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (clr_acc) begin
            col_q <= '0;
        end else if (take) begin
            col_q <= col_sum;
        end
    end

    // One parity pair per level: groups of 1, 2 and 4 bits for a byte.
    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        logic lo_par;
        logic hi_par;
        always_comb begin
            lo_par = 1'b0;
            hi_par = 1'b0;
            for (int j = 0; j < BYTE_W; j++) begin
                if (((j >> l) & 1) == 1) begin
                    hi_par = hi_par ^ col_sum[j];
                end else begin
                    lo_par = lo_par ^ col_sum[j];
                end
            end
        end
        assign col_nxt[2*l]   = lo_par;
        assign col_nxt[2*l+1] = hi_par;
    end

endmodule

// File: rtl/ecc_line_par.sv
module ecc_line_par #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_acc,
    input  logic              take,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [IDX_W-1:0]  ev_nxt,
    output logic [IDX_W-1:0]  od_nxt
);

    logic             byte_par;
    logic [IDX_W-1:0] ev_q;
    logic [IDX_W-1:0] od_q;

    assign byte_par = ^byte_in;

    for (genvar k = 0; k < IDX_W; k++) begin : g_pair
        assign ev_nxt[k] = ev_q[k] ^ (take & byte_par & ~idx[k]);
        assign od_nxt[k] = od_q[k] ^ (take & byte_par &  idx[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
            od_q <= '0;
        end else if (clr_acc) begin
            ev_q <= '0;
            od_q <= '0;
        end else if (take) begin
            ev_q <= ev_nxt;
            od_q <= od_nxt;
        end
    end

endmodule

// File: rtl/ecc_seq_fsm.sv
module ecc_seq_fsm
    import ecc_pkg::*;
#(
    parameter int BLK_BYTES = 256,
    localparam int BLK_W    = $clog2(BLK_BYTES),
    localparam int IDX_W    = BLK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic             mode_q,
    output logic             take,
    output logic [IDX_W-1:0] idx,
    output logic             clr_acc,
    output logic             latch_a,
    output logic             latch_b,
    output logic             fin
);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             blk_end;

    assign blk_end = mode_q ? (&cnt_q) : (&cnt_q[BLK_W-1:0]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + IDX_W'(1);
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        take    = byte_vld && !clr && (state_q != ST_DONE);
        latch_a = 1'b0;
        latch_b = 1'b0;
        fin     = 1'b0;
        idx     = mode_q ? cnt_q : {1'b0, cnt_q[BLK_W-1:0]};
        clr_acc = clr || (take && blk_end);
        unique case (state_q)
            ST_FIRST: begin
                if (take && blk_end) begin
                    latch_a = 1'b1;
                    fin     = mode_q;
                    state_d = mode_q ? ST_DONE : ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (take && blk_end) begin
                    latch_b = 1'b1;
                    fin     = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d = ST_FIRST;
            end
        endcase
        if (clr) begin
            state_d = ST_FIRST;
        end
    end

endmodule

// File: rtl/ecc_page_gen.sv
module ecc_page_gen
    import ecc_pkg::*;
#(
    parameter int BLK_BYTES = 256,
    localparam int IDX_W    = $clog2(BLK_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wide_mode,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              done
);

    logic                mode_q;
    logic                take;
    logic [IDX_W-1:0]    idx;
    logic                clr_acc;
    logic                latch_a;
    logic                latch_b;
    logic                fin;
    logic [IDX_W-1:0]    ev_nxt;
    logic [IDX_W-1:0]    od_nxt;
    logic [COL_BITS-1:0] col_nxt;
    logic [CODE_W-1:0]   code_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (clr) begin
            mode_q <= wide_mode;
        end
    end

    ecc_seq_fsm #(.BLK_BYTES(BLK_BYTES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .byte_vld (byte_vld),
        .mode_q   (mode_q),
        .take     (take),
        .idx      (idx),
        .clr_acc  (clr_acc),
        .latch_a  (latch_a),
        .latch_b  (latch_b),
        .fin      (fin)
    );

    ecc_line_par #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_acc (clr_acc),
        .take    (take),
        .idx     (idx),
        .byte_in (byte_in),
        .ev_nxt  (ev_nxt),
        .od_nxt  (od_nxt)
    );

    ecc_col_par #(.BYTE_W(BYTE_W)) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_acc (clr_acc),
        .take    (take),
        .byte_in (byte_in),
        .col_nxt (col_nxt)
    );

    assign code_nxt = pack_code(ev_nxt, od_nxt, col_nxt, mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_a <= '1;
            code_b <= '1;
            done   <= 1'b0;
        end else if (clr) begin
            code_a <= '1;
            code_b <= '1;
            done   <= 1'b0;
        end else begin
            if (latch_a) begin
                code_a <= code_nxt;
            end
            if (latch_b) begin
                code_b <= code_nxt;
            end
            if (fin) begin
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecc_page_gen_chk.sv
module ecc_page_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr,
    input logic        byte_vld,
    input logic        mode_q,
    input logic [23:0] code_a,
    input logic [23:0] code_b,
    input logic        done
);

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done); // R9

    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> ($stable(code_a) && $stable(code_b))); // R9

    AST_CLR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done && code_a == 24'hFFFFFF && code_b == 24'hFFFFFF)); // R10

    AST_NARROW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && done) |-> (code_a[17:16] == 2'b11 && code_b[17:16] == 2'b11)); // R7

    AST_WIDE_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (code_b == 24'hFFFFFF)); // R3

    AST_DONE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(byte_vld)); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !clr) |=> ($stable(code_a) && $stable(code_b) && $stable(done))); // R12

endmodule

bind ecc_page_gen ecc_page_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .byte_vld (byte_vld),
    .mode_q   (mode_q),
    .code_a   (code_a),
    .code_b   (code_b),
    .done     (done)
);

// File: tb/sim_ecc_page_gen.sv
module sim_ecc_page_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        wide_mode = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [23:0] code_a;
    logic [23:0] code_b;
    logic        done;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [7:0] mem [512];

    always #2.5 clk = ~clk;

    ecc_page_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wide_mode (wide_mode),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .code_a    (code_a),
        .code_b    (code_b),
        .done      (done)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected code computed straight from the parity definitions
    function automatic logic [23:0] model(input int start, input int n, input bit wide);
        logic [8:0]  ev;
        logic [8:0]  od;
        logic [7:0]  c;
        logic [5:0]  cp;
        logic [23:0] raw;
        logic [7:0]  b;
        ev = '0; od = '0; c = '0; cp = '0; raw = '0;
        for (int i = 0; i < n; i++) begin
            b = mem[start + i];
            c = c ^ b;
            for (int k = 0; k < 9; k++) begin
                if (((i >> k) & 1) == 1) od[k] = od[k] ^ (^b);
                else                     ev[k] = ev[k] ^ (^b);
            end
        end
        for (int l = 0; l < 3; l++) begin
            for (int j = 0; j < 8; j++) begin
                if (((j >> l) & 1) == 1) cp[2*l+1] = cp[2*l+1] ^ c[j];
                else                     cp[2*l]   = cp[2*l]   ^ c[j];
            end
        end
        for (int k = 0; k < 8; k++) begin
            raw[2*k]   = ev[k];
            raw[2*k+1] = od[k];
        end
        if (wide) begin
            raw[16] = ev[8];
            raw[17] = od[8];
        end
        raw[23:18] = cp;
        return ~raw;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * seed + (i >> 3) * 11 + seed) & 8'hFF);
    endtask

    task automatic fill_const(input logic [7:0] v);
        for (int i = 0; i < 512; i++) mem[i] = v;
    endtask

    task automatic do_clr(input bit mode, input bit with_byte);
        @(negedge clk);
        clr = 1'b1;
        wide_mode = mode;
        byte_vld = with_byte;
        byte_in = 8'hC3;
        @(negedge clk);
        clr = 1'b0;
        byte_vld = 1'b0;
    endtask

    task automatic feed(input int start, input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 3 == 0)) begin
                @(negedge clk);
                byte_vld = 1'b0;
                byte_in = 8'h5A;
            end
            @(negedge clk);
            byte_vld = 1'b1;
            byte_in = mem[start + i];
        end
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 code_a", code_a, 24'hFFFFFF);
        check("R1 code_b", code_b, 24'hFFFFFF);
        check("R1 done", {23'd0, done}, 24'd0);
    endtask

    task automatic t_all_ones;
        fill_const(8'hFF);
        do_clr(1'b0, 1'b0);
        feed(0, 512, 1'b0);
        check("R7 all-FF code_a", code_a, 24'hFFFFFF);
        check("R7 all-FF code_b", code_b, 24'hFFFFFF);
        check("R8 done narrow", {23'd0, done}, 24'd1);
    endtask

    task automatic t_hand;
        fill_const(8'h00);
        mem[0] = 8'h01;
        mem[511] = 8'h80;
        do_clr(1'b0, 1'b0);
        feed(0, 512, 1'b0);
        check("R4 R5 R6 hand code_a", code_a, 24'hABAAAA);
        check("R4 R5 R6 hand code_b", code_b, 24'h575555);
    endtask

    task automatic t_narrow;
        fill(37);
        do_clr(1'b0, 1'b0);
        feed(0, 255, 1'b1);
        check("R2 code_a before byte 255", code_a, 24'hFFFFFF);
        feed(255, 1, 1'b0);
        check("R2 R12 code_a", code_a, model(0, 256, 1'b0));
        check("R7 narrow pad", {22'd0, code_a[17:16]}, 24'd3);
        check("R8 done after first page", {23'd0, done}, 24'd0);
        feed(256, 256, 1'b0);
        check("R2 code_b", code_b, model(256, 256, 1'b0));
        check("R8 done after second page", {23'd0, done}, 24'd1);
    endtask

    task automatic t_freeze;
        logic [23:0] a0;
        logic [23:0] b0;
        a0 = code_a;
        b0 = code_b;
        fill(91);
        feed(0, 40, 1'b0);
        check("R9 code_a frozen", code_a, a0);
        check("R9 code_b frozen", code_b, b0);
        check("R9 done held", {23'd0, done}, 24'd1);
    endtask

    task automatic t_wide;
        fill(53);
        do_clr(1'b1, 1'b0);
        feed(0, 511, 1'b0);
        check("R3 code_a before byte 511", code_a, 24'hFFFFFF);
        check("R8 done before byte 511", {23'd0, done}, 24'd0);
        feed(511, 1, 1'b0);
        check("R3 wide code_a", code_a, model(0, 512, 1'b1));
        check("R3 wide code_b", code_b, 24'hFFFFFF);
        check("R8 done wide", {23'd0, done}, 24'd1);
    endtask

    task automatic t_restart;
        fill(29);
        do_clr(1'b0, 1'b0);
        feed(0, 100, 1'b0);
        do_clr(1'b0, 1'b1);
        check("R10 code_a after clr", code_a, 24'hFFFFFF);
        check("R10 done after clr", {23'd0, done}, 24'd0);
        feed(0, 512, 1'b0);
        check("R10 restart code_a", code_a, model(0, 256, 1'b0));
        check("R10 restart code_b", code_b, model(256, 256, 1'b0));
    endtask

    task automatic t_mode_latch;
        fill(17);
        do_clr(1'b1, 1'b0);
        wide_mode = 1'b0;
        feed(0, 256, 1'b0);
        check("R11 no latch at 256", {23'd0, done}, 24'd0);
        feed(256, 256, 1'b0);
        check("R11 wide code kept", code_a, model(0, 512, 1'b1));
    endtask

    task automatic t_flip;
        logic [23:0] a0;
        fill(73);
        do_clr(1'b0, 1'b0);
        feed(0, 256, 1'b0);
        a0 = code_a;
        mem[166] = mem[166] ^ 8'h20;
        do_clr(1'b0, 1'b0);
        feed(0, 256, 1'b0);
        check("R13 narrow distance", 24'($countones(a0 ^ code_a)), 24'd11);
        fill(73);
        do_clr(1'b1, 1'b0);
        feed(0, 512, 1'b0);
        a0 = code_a;
        mem[300] = mem[300] ^ 8'h04;
        do_clr(1'b1, 1'b0);
        feed(0, 512, 1'b0);
        check("R13 wide distance", 24'($countones(a0 ^ code_a)), 24'd12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_ones();
        t_hand();
        t_narrow();
        t_freeze();
        t_wide();
        t_restart();
        t_mode_latch();
        t_flip();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule